// File: doc/BRIEF.md
# External Destination Address Matcher

This block sits next to an Ethernet receiver and filters frames by destination address. It watches the decoded serial receive stream, clocked by the recovered bit clock, together with a framing strobe. The strobe goes high when the first destination-address bit is presented and then toggles at every later byte boundary. The block collects the six destination octets and hands the finished address into the system clock domain. There it compares the address with a small register table that software loads through a write port. If no valid entry matches, the block pulls an active-low reject line for a fixed number of system clock cycles.

The reject decision is only worth making while the receiver still listens for it. For that reason the block opens a window of a set number of system cycles at each frame start. It stays silent if the address arrives after the window has closed. The recovered clock stops between frames. A receive-busy input therefore clears the partial capture state asynchronously, so a runt frame leaves nothing behind for the next one.

Top module: `extAddrMatch`

## Requirements
- R1: After reset `rejectN` is high and every table entry is invalid, so a frame received before any write is rejected.
- R2: Address capture begins at the first rising edge of `frameStrobe` seen while `rxBusy` is high. Serial bits presented before that edge (preamble and delimiter) do not affect the address.
- R3: Byte boundaries come only from `frameStrobe` changes. The address is complete at the sixth change after the starting rise, and later bits (source address, payload) do not alter the compared address.
- R4: Octet k of the frame (k = 0 first on the line) occupies `wrAddr`/table bits [8k+7:8k], and bit 0 of each octet is the first received. An address with its octets in a different order does not match.
- R5: The table holds NUM_ENTRIES 48-bit entries, each with a valid bit. An exact match with any valid entry suppresses the reject.
- R6: When no valid entry matches, `rejectN` goes low exactly once for that frame and stays low for exactly PULSE_CYCLES system clock cycles.
- R7: A reject is issued only if the address is complete within WINDOW_CYCLES system cycles after the synchronised frame start. A later address produces no pulse.
- R8: `rxBusy` low clears the serial capture state. A frame that ends before six bytes produces no reject, and the next frame is judged only on its own address.
- R9: A write with `wrEn` high stores `wrAddr` and `wrValid` into entry `wrIdx`. A write with `wrValid` low invalidates that entry, so its address is rejected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the table, window and reject pulse |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| serClk | input | 1 | Recovered receive bit clock, running only during frames |
| serData | input | 1 | Decoded receive bit, sampled on rising `serClk` |
| frameStrobe | input | 1 | Rises at the first address bit, then toggles at each byte boundary |
| rxBusy | input | 1 | High while the receiver delivers a frame; low clears capture |
| wrEn | input | 1 | Table write strobe (sysClk domain) |
| wrIdx | input | $clog2(NUM_ENTRIES) | Table entry to write |
| wrAddr | input | 48 | Address to store, octet 0 in bits [7:0] |
| wrValid | input | 1 | Valid bit stored with the entry |
| rejectN | output | 1 | Active-low reject pulse |

## Verification
Embedded properties check the following on every cycle:
- the serial byte counter never passes six;
- the handed-over address changes only when a completion toggle is produced;
- every reject pulse lasts exactly the configured width;
- a pulse never starts while a valid entry hits or after the window has closed.

Only the bench scenarios can show end-to-end results that depend on the whole frame. These are the octet and bit order, the effect of preamble noise and trailing payload, a runt frame followed by a normal one, a slow bit rate that overruns the window, and table rewrites that invalidate an entry.

// File: rtl/extAddrMatchPkg.sv
package extAddrMatchPkg;
  localparam int ADDR_W = 48;
  localparam int OCTETS = 6;

  typedef struct packed {
    logic winStart;
    logic evalNow;
    logic fire;
  } ctrlStrobes_t;

  typedef struct packed {
    logic hit;
    logic winOpen;
  } dpStatus_t;
endpackage

// File: rtl/addrCapture.sv
module addrCapture #(
  parameter int ADDR_W = 48,
  parameter int OCTETS = 6
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              rxBusy,
  input  logic              serData,
  input  logic              frameStrobe,
  output logic              startTgl,
  output logic              doneTgl,
  output logic [ADDR_W-1:0] holdAddr
);
  localparam int CNT_W = $clog2(OCTETS + 1);

  logic              clrN;
  logic              prevStrobe;
  logic              inFrame;
  logic [CNT_W-1:0]  byteCnt;
  logic [ADDR_W-1:0] shiftReg;
  logic              strobeEdge, startNow, doneNow, shiftNow;

  assign clrN = rstN & rxBusy;

  always_comb begin
    strobeEdge = frameStrobe != prevStrobe;
    startNow   = !inFrame && frameStrobe && !prevStrobe;
    doneNow    = inFrame && strobeEdge && (byteCnt == CNT_W'(OCTETS - 1));
    shiftNow   = startNow || (inFrame && (byteCnt < CNT_W'(OCTETS)) && !doneNow);
  end

  // capture state, wiped whenever the receiver is idle (R8)
  always_ff @(posedge serClk or negedge clrN) begin
    if (!clrN) begin
      prevStrobe <= 1'b0;
      inFrame    <= 1'b0;
      byteCnt    <= '0;
      shiftReg   <= '0;
    end else begin
      prevStrobe <= frameStrobe;
      if (startNow) begin
        inFrame  <= 1'b1;
        byteCnt  <= '0;
        shiftReg <= {serData, {(ADDR_W-1){1'b0}}};
      end else begin
        if (inFrame && strobeEdge && byteCnt < CNT_W'(OCTETS))
          byteCnt <= byteCnt + 1'b1;
        if (shiftNow)
          shiftReg <= {serData, shiftReg[ADDR_W-1:1]};  // LSB first (R4)
      end
    end
  end

  // hand-over state survives frame gaps
  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      startTgl <= 1'b0;
      doneTgl  <= 1'b0;
      holdAddr <= '0;
    end else begin
      if (startNow) startTgl <= ~startTgl;
      if (doneNow) begin
        doneTgl  <= ~doneTgl;
        holdAddr <= shiftReg;
      end
    end
  end

  a_r3_byte_bound: assert property (@(posedge serClk) disable iff (!clrN)
    byteCnt <= CNT_W'(OCTETS));

  a_r3_hold_on_done: assert property (@(posedge serClk) disable iff (!rstN)
    !$stable(holdAddr) |-> (doneTgl != $past(doneTgl)));
endmodule

// File: rtl/rejectCtrl.sv
module rejectCtrl
  import extAddrMatchPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         sysClk,
  input  logic         rstN,
  input  logic         startTgl,
  input  logic         doneTgl,
  input  dpStatus_t    stat,
  output ctrlStrobes_t ctrl
);
  logic [SYNC_STAGES:0] startSync;
  logic [SYNC_STAGES:0] doneSync;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      startSync <= '0;
      doneSync  <= '0;
    end else begin
      startSync <= {startSync[SYNC_STAGES-1:0], startTgl};
      doneSync  <= {doneSync[SYNC_STAGES-1:0], doneTgl};
    end
  end

  always_comb begin
    ctrl.winStart = startSync[SYNC_STAGES] ^ startSync[SYNC_STAGES-1];
    ctrl.evalNow  = doneSync[SYNC_STAGES] ^ doneSync[SYNC_STAGES-1];
    ctrl.fire     = ctrl.evalNow && !stat.hit && stat.winOpen;
  end
endmodule

// File: rtl/matchDatapath.sv
module matchDatapath
  import extAddrMatchPkg::*;
#(
  parameter int NUM_ENTRIES   = 4,
  parameter int ADDR_W        = 48,
  parameter int WINDOW_CYCLES = 512,
  parameter int PULSE_CYCLES  = 15
) (
  input  logic                           sysClk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wrIdx,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic                           wrValid,
  input  logic [ADDR_W-1:0]              holdAddr,
  input  ctrlStrobes_t                   ctrl,
  output dpStatus_t                      stat,
  output logic                           rejectN
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);
  localparam int PUL_W = $clog2(PULSE_CYCLES + 1);

  logic [ADDR_W-1:0]      entryAddr  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entryValid;
  logic [NUM_ENTRIES-1:0] entryHit;
  logic [WIN_W-1:0]       winCnt;
  logic                   winOpen;
  logic [PUL_W-1:0]       pulseCnt;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    always_ff @(posedge sysClk or negedge rstN) begin
      if (!rstN) begin
        entryAddr[i]  <= '0;
        entryValid[i] <= 1'b0;
      end else if (wrEn && wrIdx == IDX_W'(i)) begin
        entryAddr[i]  <= wrAddr;
        entryValid[i] <= wrValid;
      end
    end
    assign entryHit[i] = entryValid[i] && (entryAddr[i] == holdAddr);
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      winOpen <= 1'b0;
    end else if (ctrl.winStart) begin
      winCnt  <= '0;
      winOpen <= 1'b1;
    end else if (winOpen) begin
      if (winCnt == WIN_W'(WINDOW_CYCLES - 1)) winOpen <= 1'b0;
      else winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (ctrl.fire) pulseCnt <= PUL_W'(PULSE_CYCLES);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign stat.hit     = |entryHit;
  assign stat.winOpen = winOpen;
  assign rejectN      = (pulseCnt == '0);

  logic [PUL_W:0] lowRun;
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (rejectN) lowRun <= '0;
    else lowRun <= lowRun + 1'b1;
  end

  a_r6_pulse_width: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(rejectN) |-> (lowRun == (PUL_W+1)'(PULSE_CYCLES)));

  a_r7_window_open: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(rejectN) |-> $past(winOpen));

  a_r5_no_reject_on_hit: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(rejectN) |-> !$past(stat.hit));
endmodule

// File: rtl/extAddrMatch.sv
module extAddrMatch
  import extAddrMatchPkg::*;
#(
  parameter int NUM_ENTRIES   = 4,
  parameter int WINDOW_CYCLES = 512,
  parameter int PULSE_CYCLES  = 15,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                           sysClk,
  input  logic                           rstN,
  input  logic                           serClk,
  input  logic                           serData,
  input  logic                           frameStrobe,
  input  logic                           rxBusy,
  input  logic                           wrEn,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wrIdx,
  input  logic [47:0]                    wrAddr,
  input  logic                           wrValid,
  output logic                           rejectN
);
  logic              startTgl, doneTgl;
  logic [ADDR_W-1:0] holdAddr;
  ctrlStrobes_t      ctrl;
  dpStatus_t         stat;

  addrCapture #(.ADDR_W(ADDR_W), .OCTETS(OCTETS)) u_capture (
    .serClk(serClk), .rstN(rstN), .rxBusy(rxBusy), .serData(serData),
    .frameStrobe(frameStrobe), .startTgl(startTgl), .doneTgl(doneTgl),
    .holdAddr(holdAddr)
  );

  rejectCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk(sysClk), .rstN(rstN), .startTgl(startTgl), .doneTgl(doneTgl),
    .stat(stat), .ctrl(ctrl)
  );

  matchDatapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W),
    .WINDOW_CYCLES(WINDOW_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dp (
    .sysClk(sysClk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrAddr(wrAddr), .wrValid(wrValid), .holdAddr(holdAddr),
    .ctrl(ctrl), .stat(stat), .rejectN(rejectN)
  );
endmodule

// File: tb/extAddrMatch_bench.sv
`timescale 1ns/1ps
module extAddrMatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 15;
  localparam int NENT       = 4;

  logic sysClk = 1'b0, rstN = 1'b0, serClk = 1'b0, serData = 1'b0;
  logic frameStrobe = 1'b0, rxBusy = 1'b0, wrEn = 1'b0, wrValid = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic [47:0] wrAddr = '0;
  logic rejectN;

  int checks = 0, errors = 0;
  int pulses = 0, lastWidth = 0, lowRun = 0;
  bit    expQ[$];
  string tagQ[$];
  event  frameDone;

  extAddrMatch #(.NUM_ENTRIES(NENT), .PULSE_CYCLES(PULSE)) u_extAddrMatch (
    .sysClk(sysClk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .frameStrobe(frameStrobe), .rxBusy(rxBusy), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrAddr(wrAddr), .wrValid(wrValid), .rejectN(rejectN)
  );

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure reject pulses
  always @(negedge sysClk) begin
    if (!rstN) begin
      lowRun <= 0;
    end else if (!rejectN) begin
      lowRun <= lowRun + 1;
    end else if (lowRun != 0) begin
      pulses    <= pulses + 1;
      lastWidth <= lowRun;
      lowRun    <= 0;
    end
  end

  // scoreboard
  initial begin
    forever begin
      @(frameDone);
      if (expQ.size() == 0) begin
        check(0, "scoreboard", 0, 1);
      end else begin
        automatic bit    e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(pulses == (e ? 1 : 0), t, pulses, e ? 1 : 0);
        if (e && pulses == 1) check(lastWidth == PULSE, {t, " width R6"}, lastWidth, PULSE);
      end
      pulses = 0;
    end
  end

  task automatic writeEntry(int idx, logic [47:0] a, bit v);
    @(negedge sysClk);
    wrEn = 1'b1; wrIdx = idx[1:0]; wrAddr = a; wrValid = v;
    @(negedge sysClk);
    wrEn = 1'b0;
  endtask

  task automatic serBit(bit d, bit s, int half);
    serData = d; frameStrobe = s;
    #(half) serClk = 1'b1;
    #(half) serClk = 1'b0;
  endtask

  // driver: one frame, nBytes total bytes after the delimiter
  task automatic sendFrame(logic [47:0] da, int nBytes, int half, bit expRej,
                           string tag, logic [7:0] pre);
    expQ.push_back(expRej); tagQ.push_back(tag);
    rxBusy = 1'b1;
    #(half);
    for (int i = 0; i < 16; i++) serBit(pre[i % 8], 1'b0, half);
    for (int b = 0; b < nBytes; b++) begin
      automatic logic [7:0] oct = (b < 6) ? da[8*b +: 8] : 8'(8'h3C ^ b);
      for (int k = 0; k < 8; k++) serBit(oct[k], ~b[0], half);
    end
    rxBusy = 1'b0; frameStrobe = 1'b0; serData = 1'b0;
    repeat (60) @(negedge sysClk);
    -> frameDone;
    #1;
  endtask

  localparam logic [47:0] ADDR_A = 48'h5A_44_33_22_11_02;
  localparam logic [47:0] ADDR_B = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] ADDR_C = 48'h01_23_45_67_89_AB;
  localparam logic [47:0] ADDR_D = 48'hCA_FE_00_12_34_56;

  initial begin
    repeat (3) @(negedge sysClk);
    check(rejectN == 1'b1, "R1 reset rejectN", rejectN, 1);
    rstN = 1'b1;
    repeat (3) @(negedge sysClk);
    check(rejectN == 1'b1, "R1 after reset", rejectN, 1);

    sendFrame(ADDR_A, 16, 20, 1'b1, "R1 empty table rejects", 8'h55);
    writeEntry(0, ADDR_A, 1'b1);
    writeEntry(1, ADDR_B, 1'b1);
    writeEntry(2, ADDR_C, 1'b0);
    sendFrame(ADDR_A, 16, 20, 1'b0, "R5 hit entry0", 8'h55);
    sendFrame(ADDR_B, 16, 20, 1'b0, "R5 hit entry1", 8'h55);
    sendFrame(ADDR_C, 16, 20, 1'b1, "R9 invalid entry rejects", 8'h55);
    sendFrame(ADDR_D, 16, 20, 1'b1, "R6 unknown rejects once", 8'h55);
    sendFrame(ADDR_A, 16, 20, 1'b0, "R2 preamble noise ignored", 8'hD3);
    sendFrame(ADDR_A, 30, 20, 1'b0, "R3 trailing payload ignored", 8'h55);
    sendFrame(ADDR_A ^ 48'h80_00_00_00_00_00, 16, 20, 1'b1, "R4 last bit differs", 8'h55);
    sendFrame({ADDR_A[7:0], ADDR_A[15:8], ADDR_A[23:16], ADDR_A[31:24],
               ADDR_A[39:32], ADDR_A[47:40]}, 16, 20, 1'b1, "R4 octet order", 8'h55);
    sendFrame(ADDR_D, 16, 60, 1'b0, "R7 late address no reject", 8'h55);
    sendFrame(ADDR_D, 16, 20, 1'b1, "R7 in-window reject", 8'h55);
    sendFrame(ADDR_D, 3, 20, 1'b0, "R8 runt no decision", 8'h55);
    sendFrame(ADDR_A, 16, 20, 1'b0, "R8 after runt hit", 8'h55);
    sendFrame(ADDR_D, 16, 20, 1'b1, "R8 after runt miss", 8'h55);
    writeEntry(0, ADDR_A, 1'b0);
    sendFrame(ADDR_A, 16, 20, 1'b1, "R9 invalidated entry", 8'h55);
    writeEntry(3, ADDR_A, 1'b1);
    sendFrame(ADDR_A, 16, 20, 1'b0, "R9 rewritten entry3", 8'h55);
    check(rejectN == 1'b1, "R6 idle high", rejectN, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sysClk);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule